// File: doc/BRIEF.md
# Step-Configurable Counter with Rate Divider

This block holds a W-bit register that, on every clock edge where its enable is high, adds a run-time step value taken from an input port. The sum wraps modulo 2^W. Reset is synchronous and overrides everything else. The count is registered, so a new value appears at the output one cycle after the edge that produced it.

The same counter core is instantiated a second time as the heart of a rate divider. In that instance the step is tied to one. The divider has its own enable input. When that counter reaches a parameterized terminal value TERM on an enabled edge, it is cleared. On that same edge a registered one-cycle strobe is raised and a registered square-wave output is inverted. The strobe therefore recurs every TERM+1 enabled cycles. The square wave has a period of 2*(TERM+1) enabled cycles. Both outputs are plain logic signals meant as enables, not as clocks to be routed.

Top module: `stepdiv_top`

## Requirements
- R1: While rst_i is high at a clock edge, the following edge leaves count_o at 0, tick_o at 0 and clk_o at 0, even if cnt_en_i and div_en_i are high.
- R2: An edge with cnt_en_i low leaves count_o unchanged, whatever value step_i carries.
- R3: An edge with cnt_en_i high makes count_o equal to its previous value plus step_i, visible right after that edge.
- R4: The sum is taken modulo 2^W, so a count that passes 2^W-1 wraps to the remainder.
- R5: With div_en_i held high, tick_o is high for exactly one cycle, and rises once every TERM+1 cycles.
- R6: clk_o inverts in the cycle where tick_o is high and is stable in every other cycle, giving a square wave of period 2*(TERM+1) enabled cycles.
- R7: While div_en_i is low, tick_o stays low and clk_o holds, and the divider keeps its phase: once enabled again it finishes the interrupted period.
- R8: A step of zero with cnt_en_i high leaves count_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Enable for the stepping counter |
| step_i | input | W | Value added per enabled cycle |
| count_o | output | W | Registered count |
| div_en_i | input | 1 | Enable for the divider |
| tick_o | output | 1 | One-cycle strobe every TERM+1 enabled cycles |
| clk_o | output | 1 | Divided square wave, toggles on each strobe |

## Verification
A corrupted count register shows at count_o on the very next edge, because every enabled cycle exposes the previous value plus the step. A hold that leaks shows as a change while the enable is low. A wrong divider state is hidden at first: an offset phase, or a terminal compare that is off by one, only shows when tick_o arrives one or more cycles early or late. That takes up to TERM+1 cycles. The square wave then shows the same error as a half-period of the wrong length. For that reason the bench measures the gap between strobes, as well as comparing the outputs cycle by cycle.

// File: rtl/stepdiv_top.sv
module stepdiv_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) q_o <= '0;
    else if (en_i)      q_o <= q_o + step_i;
  end
endmodule

module stepdiv_top #(
  parameter int W    = 8,
  parameter int TERM = 9
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] count_o,
  input  logic         div_en_i,
  output logic         tick_o,
  output logic         clk_o
);
  localparam int DW = (TERM < 1) ? 1 : $clog2(TERM + 1);

  logic [DW-1:0] phase;
  logic          wrap;

  stepdiv_counter #(.W(W)) u_main (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (1'b0),
    .en_i   (cnt_en_i),
    .step_i (step_i),
    .q_o    (count_o)
  );

  stepdiv_counter #(.W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (wrap),
    .en_i   (div_en_i),
    .step_i (DW'(1)),
    .q_o    (phase)
  );

  assign wrap = div_en_i && (phase == DW'(TERM));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tick_o <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      tick_o <= wrap;
      if (wrap) clk_o <= ~clk_o;
    end
  end
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk #(
  parameter int W    = 8,
  parameter int TERM = 9
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         cnt_en_i,
  input logic [W-1:0] step_i,
  input logic [W-1:0] count_o,
  input logic         div_en_i,
  input logic         tick_o,
  input logic         clk_o
);
  AST_RST_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0) && !tick_o && !clk_o); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !cnt_en_i |=> count_o == $past(count_o)); // R2

  AST_STEP_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_en_i |=> count_o == W'($past(count_o) + $past(step_i))); // R3

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> clk_o != $past(clk_o)); // R6

  AST_STEADY_OFF_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_o |-> $stable(clk_o)); // R6

  AST_FROZEN_DIV: assert property (@(posedge clk_i) disable iff (rst_i)
    !div_en_i |=> !tick_o); // R7

  generate
    if (TERM > 0) begin : g_single
      AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o); // R5
    end
  endgenerate
endmodule

bind stepdiv_top stepdiv_chk #(.W(W), .TERM(TERM)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .cnt_en_i (cnt_en_i),
  .step_i   (step_i),
  .count_o  (count_o),
  .div_en_i (div_en_i),
  .tick_o   (tick_o),
  .clk_o    (clk_o)
);

// File: tb/sim_stepdiv_top.sv
module sim_stepdiv_top;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int TERM = 5;

  logic         clk_i = 1'b0;
  logic         rst_i = 1'b1;
  logic         cnt_en_i = 1'b0;
  logic [W-1:0] step_i = '0;
  logic         div_en_i = 1'b0;
  logic [W-1:0] count_o;
  logic         tick_o, clk_o;

  int applied = 0, failed = 0, ncyc = 0;
  bit done = 0;

  logic [W-1:0] m_cnt = '0;
  int           m_ph = 0;
  logic         m_tick = 0, m_clk = 0;

  stepdiv_top #(.W(W), .TERM(TERM)) u0 (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_en_i(cnt_en_i), .step_i(step_i),
    .count_o(count_o), .div_en_i(div_en_i), .tick_o(tick_o), .clk_o(clk_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, ncyc, act, exp);
    end
  endtask

  task automatic cyc();
    if (rst_i) begin
      m_cnt = '0; m_ph = 0; m_tick = 0; m_clk = 0;
    end else begin
      if (cnt_en_i) m_cnt = W'(m_cnt + step_i);
      m_tick = 0;
      if (div_en_i) begin
        if (m_ph == TERM) begin m_ph = 0; m_tick = 1; m_clk = ~m_clk; end
        else m_ph++;
      end
    end
    @(posedge clk_i); #1;
    ncyc++;
  endtask

  task automatic t_reset();
    rst_i = 1; cnt_en_i = 1; div_en_i = 1; step_i = 8'd3;
    repeat (3) cyc();
    chk("R1 count", count_o, 0);
    chk("R1 tick", tick_o, 0);
    chk("R1 clk_o", clk_o, 0);
    rst_i = 0; cnt_en_i = 0; div_en_i = 0;
  endtask

  task automatic t_step();
    logic [W-1:0] seq [6] = '{8'd1, 8'd2, 8'd7, 8'd16, 8'd33, 8'd5};
    logic [W-1:0] acc = count_o;
    cnt_en_i = 1;
    foreach (seq[i]) begin
      step_i = seq[i]; acc = W'(acc + seq[i]);
      cyc();
      chk("R3 add", count_o, acc);
    end
    cnt_en_i = 0;
  endtask

  task automatic t_hold();
    logic [W-1:0] keep = count_o;
    cnt_en_i = 0; step_i = 8'd7;
    for (int i = 0; i < 4; i++) begin cyc(); chk("R2 hold", count_o, keep); end
    cnt_en_i = 1; step_i = 8'd0;
    for (int i = 0; i < 3; i++) begin cyc(); chk("R8 zero step", count_o, keep); end
    cnt_en_i = 0;
  endtask

  task automatic t_wrap();
    rst_i = 1; cyc(); rst_i = 0;
    cnt_en_i = 1; step_i = 8'd200;
    cyc(); chk("R4 first", count_o, 8'd200);
    cyc(); chk("R4 wrap", count_o, 8'd144);
    step_i = 8'd255;
    cyc(); chk("R4 wrap255", count_o, 8'd143);
    cnt_en_i = 0;
  endtask

  task automatic t_rst_prio();
    cnt_en_i = 1; step_i = 8'd9;
    cyc(); cyc();
    chk("R3 pre-reset", count_o, m_cnt);
    rst_i = 1; cyc();
    chk("R1 priority", count_o, 0);
    rst_i = 0; cnt_en_i = 0;
  endtask

  task automatic t_div();
    int last = -1;
    rst_i = 1; cyc(); rst_i = 0;
    div_en_i = 1;
    for (int i = 0; i < 6 * (TERM + 1); i++) begin
      cyc();
      chk("R5 tick", tick_o, m_tick);
      chk("R6 clk_o", clk_o, m_clk);
      if (tick_o) begin
        if (last >= 0) chk("R5 spacing", ncyc - last, TERM + 1);
        last = ncyc;
      end
    end
    div_en_i = 0;
  endtask

  task automatic t_div_freeze();
    logic held;
    div_en_i = 1;
    repeat (2) cyc();
    div_en_i = 0;
    held = clk_o;
    for (int i = 0; i < 2 * (TERM + 1); i++) begin
      cyc();
      chk("R7 no tick", tick_o, 0);
      chk("R7 clk_o held", clk_o, held);
    end
    div_en_i = 1;
    for (int i = 0; i < 3 * (TERM + 1); i++) begin
      cyc();
      chk("R7 resume tick", tick_o, m_tick);
      chk("R7 resume clk_o", clk_o, m_clk);
    end
    div_en_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1; failed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_step();
    t_hold();
    t_wrap();
    t_rst_prio();
    t_div();
    t_div_freeze();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end
endmodule